// File: doc/BRIEF.md
# HDLC Serial Frame Transmitter

This block turns a stream of whole bytes from a backend into a synchronous bit-oriented HDLC line signal. Everything runs on the line clock supplied from outside. A frame opens with a flag byte, carries the data bytes least significant bit first, and carries a complemented frame check sequence after the data. A closing flag ends the frame. Inside the data and the check sequence, a zero is inserted after any run of five ones, so that a flag cannot appear there. Between frames the line rests at one. After each frame the block sends a programmable number of extra one bits before it accepts the next frame.

The backend sees one handshake. `byte_ready` asks for a byte, and `wr_en` with `wr_data` delivers it. `wr_last` marks the final byte of the frame. During a frame the backend has seven line-clock pulses after `byte_ready` rises to deliver the next byte. If it misses that window, the block finishes the byte it is shifting, sends an abort (seven ones) and drops the frame. The backend can also force an abort with `abort_req`. The check polynomial is chosen at build time: CRC-16 (`CRC_SEL`=0) or CRC-32 (`CRC_SEL`=1).

Control is one state machine. The states are ST_IDLE (line at one, waiting for a first byte), ST_OPEN (opening flag), ST_DATA (data bits), ST_FCS (check bits), ST_CLOSE (closing flag), ST_ABORT (seven ones) and ST_GAP (extra idle ones). The transitions are:

- IDLE to OPEN on an accepted write.
- OPEN to DATA after flag bit 7.
- DATA to DATA when a byte ends and another is buffered.
- DATA to FCS when the last byte ends.
- DATA to ABORT when a byte ends with no byte buffered and the current byte is not the last.
- OPEN, DATA or FCS to ABORT on `abort_req`.
- FCS to CLOSE after the last check bit, plus any zero stuffed after it.
- CLOSE or ABORT to GAP, or straight to IDLE when `idle_len` is 0.
- GAP to IDLE after `idle_len` bits.

Top module: `hdlc_tx`

## Requirements
- R1: After reset, `tx_bit` is 1 and `byte_ready` is 1. While no frame is in progress, `tx_bit` stays 1.
- R2: A write accepted in idle starts a frame. `tx_bit` carries the flag 0x7E least significant bit first (0,1,1,1,1,1,1,0), beginning one clock after the clock edge that accepted the write.
- R3: Data bytes follow the opening flag with no gap, in write order, each least significant bit first.
- R4: Within the data and the check sequence, after five consecutive ones a 0 is sent that carries no data. This holds across byte boundaries and also after the final check bit. Flags and abort bits are never stuffed.
- R5: With `CRC_SEL`=0 the check sequence is reflected CRC-16 (polynomial 0x8408, preset 0xFFFF) over the data bits, sent complemented and least significant bit first. `CRC_SEL`=1 selects reflected CRC-32 (0xEDB88320, preset all ones) in the same way.
- R6: The closing flag follows the check sequence. It is followed by `idle_len` one bits. `byte_ready` is 0 through the closing flag and the gap, and becomes 1 in the clock where `tx_bit` carries the last gap bit. With `idle_len`=0 this is the last closing-flag bit.
- R7: When a byte that is not marked last moves into the shifter, `byte_ready` rises. A write on any of the next seven clock edges is accepted, and `byte_ready` falls after the accepting edge.
- R8: If no write arrives in the seven-edge window, `byte_ready` falls and the byte in the shifter is completed. Then seven 1 bits (abort), the gap, and idle follow. A write after the window is ignored.
- R9: `abort_req` sampled during the opening flag, data or check sequence makes `tx_bit` 1 from the next bit on, for seven bits, then the gap. The frame is dropped.
- R10: `abort_req` in idle, and writes while `byte_ready` is 0, have no effect on `tx_bit` or `byte_ready`.
- R11: A write with `wr_last`=1 ends the data. `byte_ready` stays 0 from then until idle is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External line clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_len | input | IDLE_W | Number of one bits sent after each frame |
| wr_en | input | 1 | Byte write strobe, accepted only while `byte_ready` is 1 |
| wr_data | input | 8 | Byte to transmit |
| wr_last | input | 1 | Marks the written byte as the final data byte |
| abort_req | input | 1 | Forces an abort of the current frame |
| byte_ready | output | 1 | Block can accept a byte |
| tx_bit | output | 1 | Registered serial line output |

## Verification
Assertions watch every cycle for the following: idle and gap states drive ones, a stuffing cycle drives a zero, an abort request or an underrun leads to ST_ABORT, a write never overwrites a buffered byte, and `byte_ready` stays low after the last byte and during the gap. The CRC and window helpers also check their own control inputs. The full bit order of a frame needs the bench's end-to-end bit-stream comparison. This covers flag placement, stuffing across byte and check-sequence boundaries, the CRC value and the exact clock at which `byte_ready` returns. That comparison runs over random payloads, delays and gap lengths. The bench also shows the edge cases: a byte written on the seventh pulse, an underrun with a late write that must be ignored, and aborts in the flag and in the data.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_DATA,
        ST_FCS,
        ST_CLOSE,
        ST_ABORT,
        ST_GAP
    } tx_state_e;

    localparam logic [7:0] FLAG_BYTE   = 8'h7E;
    localparam logic [2:0] ONES_LIMIT  = 3'd5;
    localparam int         ABORT_BITS  = 7;

    function automatic int fcs_width(input int sel);
        return (sel == 1) ? 32 : 16;
    endfunction

endpackage

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc #(
    parameter int CRC_SEL = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic step,
    input  logic shift,
    input  logic din,
    output logic fcs_bit
);
    import hdlc_tx_pkg::*;

    localparam int W = fcs_width(CRC_SEL);

    logic [W-1:0] poly_c;
    logic [W-1:0] crc_q;

    generate
        if (CRC_SEL == 1) begin : g_crc32
            assign poly_c = W'(32'hEDB88320);
        end else begin : g_crc16
            assign poly_c = W'(16'h8408);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '1;
        end else if (init) begin
            crc_q <= '1;
        end else if (step) begin
            crc_q <= (crc_q >> 1) ^ ((crc_q[0] ^ din) ? poly_c : '0);
        end else if (shift) begin
            crc_q <= crc_q >> 1;
        end
    end

    assign fcs_bit = ~crc_q[0];

    // R5: accumulation and emission of the check sequence never overlap
    p_crc_mode_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(step && shift));

endmodule

// File: rtl/hdlc_tx_wr_window.sv
module hdlc_tx_wr_window #(
    parameter int WINDOW = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic wr,
    input  logic clr,
    output logic need
);
    localparam int CW = $clog2(WINDOW + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            need  <= 1'b0;
            cnt_q <= '0;
        end else if (clr) begin
            need  <= 1'b0;
            cnt_q <= '0;
        end else if (arm) begin
            need  <= 1'b1;
            cnt_q <= '0;
        end else if (need) begin
            if (wr) begin
                need <= 1'b0;
            end else if (cnt_q == CW'(WINDOW - 1)) begin
                need <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R7: a new request is only raised once the previous one is settled
    p_arm_when_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> !need);

    // R8: a request only drops through a write, a clear or a full window
    p_window_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(need) |-> ($past(wr) || $past(clr) || $past(cnt_q) == CW'(WINDOW - 1)));

endmodule

// File: rtl/hdlc_tx.sv
module hdlc_tx #(
    parameter int CRC_SEL = 0,
    parameter int IDLE_W  = 4,
    parameter int WINDOW  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDLE_W-1:0] idle_len,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              wr_last,
    input  logic              abort_req,
    output logic              byte_ready,
    output logic              tx_bit
);
    import hdlc_tx_pkg::*;

    localparam int FCS_W = fcs_width(CRC_SEL);
    localparam int CNT_W = $clog2(FCS_W + 1);

    tx_state_e         state, state_n;
    logic [CNT_W-1:0]  bit_cnt;
    logic [7:0]        shreg;
    logic [7:0]        buf_data;
    logic              buf_full;
    logic              buf_last;
    logic              cur_last;
    logic [2:0]        ones_cnt;
    logic [IDLE_W-1:0] gap_cnt;

    logic need;
    logic fcs_bit;
    logic wr_ok;
    logic stuff_now;
    logic abort_hit;
    logic cur_bit;
    logic [2:0] ones_after;
    logic byte_end;
    logic fcs_end;
    logic gap_done;
    logic arm;
    logic line_bit_c;
    logic in_frame;

    assign in_frame   = (state == ST_OPEN) || (state == ST_DATA) || (state == ST_FCS);
    assign byte_ready = (state == ST_IDLE) || need;
    assign wr_ok      = wr_en && byte_ready;
    assign abort_hit  = abort_req && in_frame;
    assign stuff_now  = ((state == ST_DATA) || (state == ST_FCS)) && (ones_cnt == ONES_LIMIT);
    assign cur_bit    = (state == ST_FCS) ? fcs_bit : shreg[0];
    assign ones_after = cur_bit ? (ones_cnt + 3'd1) : 3'd0;
    assign byte_end   = (state == ST_DATA) && !stuff_now && (bit_cnt == CNT_W'(7));
    assign fcs_end    = (state == ST_FCS) && !stuff_now && (bit_cnt == CNT_W'(FCS_W - 1));
    assign gap_done   = ({1'b0, gap_cnt} + 1'b1) == {1'b0, idle_len};

    assign arm = !abort_hit &&
                 (((state == ST_OPEN) && (bit_cnt == CNT_W'(7)) && !buf_last) ||
                  (byte_end && buf_full && !buf_last));

    hdlc_tx_crc #(.CRC_SEL(CRC_SEL)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (state == ST_IDLE),
        .step    ((state == ST_DATA) && !stuff_now),
        .shift   ((state == ST_FCS) && !stuff_now),
        .din     (shreg[0]),
        .fcs_bit (fcs_bit)
    );

    hdlc_tx_wr_window #(.WINDOW(WINDOW)) u_window (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm),
        .wr    (wr_ok),
        .clr   (state_n == ST_ABORT),
        .need  (need)
    );

    // next-state decision
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (wr_ok) state_n = ST_OPEN;
            end
            ST_OPEN: begin
                if (abort_hit)                    state_n = ST_ABORT;
                else if (bit_cnt == CNT_W'(7))    state_n = ST_DATA;
            end
            ST_DATA: begin
                if (abort_hit)                    state_n = ST_ABORT;
                else if (byte_end) begin
                    if (buf_full)                 state_n = ST_DATA;
                    else if (cur_last)            state_n = ST_FCS;
                    else                          state_n = ST_ABORT;
                end
            end
            ST_FCS: begin
                if (abort_hit)                    state_n = ST_ABORT;
                else if (stuff_now && bit_cnt == CNT_W'(FCS_W)) state_n = ST_CLOSE;
                else if (fcs_end && ones_after != ONES_LIMIT)   state_n = ST_CLOSE;
            end
            ST_CLOSE: begin
                if (bit_cnt == CNT_W'(7))
                    state_n = (idle_len == '0) ? ST_IDLE : ST_GAP;
            end
            ST_ABORT: begin
                if (bit_cnt == CNT_W'(ABORT_BITS - 1))
                    state_n = (idle_len == '0) ? ST_IDLE : ST_GAP;
            end
            ST_GAP: begin
                if (gap_done) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // datapath: counters, shifter and holding byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            buf_data <= '0;
            buf_full <= 1'b0;
            buf_last <= 1'b0;
            cur_last <= 1'b0;
            ones_cnt <= '0;
            gap_cnt  <= '0;
        end else begin
            if (wr_ok) begin
                buf_data <= wr_data;
                buf_last <= wr_last;
                buf_full <= 1'b1;
            end
            unique case (state)
                ST_IDLE: begin
                    bit_cnt  <= '0;
                    ones_cnt <= '0;
                end
                ST_OPEN: begin
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == CNT_W'(7)) begin
                        shreg    <= buf_data;
                        cur_last <= buf_last;
                        buf_full <= 1'b0;
                        ones_cnt <= '0;
                    end
                end
                ST_DATA: begin
                    if (stuff_now) begin
                        ones_cnt <= '0;
                    end else begin
                        shreg    <= shreg >> 1;
                        ones_cnt <= ones_after;
                        bit_cnt  <= bit_cnt + 1'b1;
                        if (byte_end) begin
                            bit_cnt <= '0;
                            if (buf_full) begin
                                shreg    <= buf_data;
                                cur_last <= buf_last;
                                buf_full <= 1'b0;
                            end
                        end
                    end
                end
                ST_FCS: begin
                    if (stuff_now) begin
                        ones_cnt <= '0;
                    end else begin
                        ones_cnt <= ones_after;
                        bit_cnt  <= bit_cnt + 1'b1;
                    end
                end
                ST_CLOSE, ST_ABORT: begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
                ST_GAP: begin
                    gap_cnt <= gap_cnt + 1'b1;
                end
                default: begin
                    bit_cnt <= '0;
                end
            endcase
            if (state_n != state) begin
                bit_cnt <= '0;
                gap_cnt <= '0;
            end
            if (state_n == ST_ABORT) begin
                buf_full <= 1'b0;
            end
        end
    end

    // line bit selection
    always_comb begin
        line_bit_c = 1'b1;
        unique case (state)
            ST_IDLE, ST_ABORT, ST_GAP: line_bit_c = 1'b1;
            ST_OPEN, ST_CLOSE:         line_bit_c = FLAG_BYTE[bit_cnt[2:0]];
            ST_DATA, ST_FCS:           line_bit_c = stuff_now ? 1'b0 : cur_bit;
            default:                   line_bit_c = 1'b1;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_bit <= 1'b1;
        else        tx_bit <= line_bit_c;
    end

    p_idle_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_GAP) |=> tx_bit);

    p_stuff_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_now |=> !tx_bit);

    p_no_overwrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && state == ST_DATA) |-> !buf_full);

    p_underrun_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_end && !buf_full && !cur_last && !abort_req) |=> (state == ST_ABORT));

    p_abort_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_hit |=> (state == ST_ABORT));

    p_abort_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ABORT) |=> tx_bit);

    p_gap_not_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |-> !byte_ready);

    p_last_no_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_DATA || state == ST_FCS) && cur_last) |-> !byte_ready);

endmodule

// File: tb/hdlc_tx_tb.sv
module hdlc_tx_tb;
    localparam int IDLE_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [IDLE_W-1:0] idle_len = '0;
    logic              wr_en = 1'b0;
    logic [7:0]        wr_data = '0;
    logic              wr_last = 1'b0;
    logic              abort_req = 1'b0;
    logic              byte_ready;
    logic              tx_bit;

    always #5 clk = ~clk;

    hdlc_tx #(.CRC_SEL(0), .IDLE_W(IDLE_W), .WINDOW(7)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle_len   (idle_len),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .wr_last    (wr_last),
        .abort_req  (abort_req),
        .byte_ready (byte_ready),
        .tx_bit     (tx_bit)
    );

    int   n_checks = 0;
    int   n_fail   = 0;
    logic exp_bits [0:1023];
    logic got_bits [0:1023];
    logic got_rdy  [0:1023];
    int   exp_len;
    logic [7:0] frame [0:15];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    task automatic push(input logic b);
        exp_bits[exp_len] = b;
        exp_len++;
    endtask

    task automatic stuff_bit(input logic b, inout int ones);
        if (ones == 5) begin
            push(1'b0);
            ones = 0;
        end
        push(b);
        ones = b ? ones + 1 : 0;
    endtask

    // expected line stream from the requirements; stall < 0 means a complete frame
    task automatic build_expected(input int n, input int stall, input int idle,
                                  output int idx_rdy);
        int ones = 0;
        logic [15:0] crc = 16'hFFFF;
        logic [15:0] fcs;
        int nb;
        exp_len = 0;
        for (int b = 0; b < 8; b++) push(8'h7E >> b);
        nb = (stall >= 0) ? stall : n;
        for (int i = 0; i < nb; i++) begin
            for (int b = 0; b < 8; b++) begin
                logic d;
                logic fb;
                d  = frame[i][b];
                fb = crc[0] ^ d;
                crc = crc >> 1;
                if (fb) crc = crc ^ 16'h8408;
                stuff_bit(d, ones);
            end
        end
        if (stall >= 0) begin
            for (int k = 0; k < 7; k++) push(1'b1);
        end else begin
            fcs = ~crc;
            for (int b = 0; b < 16; b++) stuff_bit(fcs[b], ones);
            if (ones == 5) push(1'b0);
            for (int b = 0; b < 8; b++) push(8'h7E >> b);
        end
        idx_rdy = exp_len - 1 + idle;
        for (int k = 0; k < idle; k++) push(1'b1);
        push(1'b1);
        push(1'b1);
    endtask

    task automatic monitor();
        for (int k = 0; k < exp_len; k++) begin
            @(negedge clk);
            got_bits[k] = tx_bit;
            got_rdy[k]  = byte_ready;
        end
    endtask

    task automatic feeder(input int n, input int stall, input int dmin, input int dmax);
        for (int i = 1; i < n; i++) begin
            int dly;
            do @(negedge clk); while (!byte_ready);
            dly = (i == stall) ? 7 : int'($urandom_range(dmax, dmin));
            repeat (dly) @(negedge clk);
            wr_en   = 1'b1;
            wr_data = frame[i];
            wr_last = (i == n - 1);
            @(negedge clk);
            wr_en   = 1'b0;
            if (i == stall) break;
        end
    endtask

    task automatic compare(input string req, input int idx_rdy);
        int bad = -1;
        for (int k = 0; k < exp_len; k++)
            if (bad < 0 && got_bits[k] !== exp_bits[k]) bad = k;
        check(bad < 0, req, $sformatf("line stream, first bad bit %0d", bad),
              (bad < 0) ? 0 : int'(got_bits[bad]), (bad < 0) ? 0 : int'(exp_bits[bad]));
        check(got_rdy[idx_rdy] === 1'b1, "R6", "byte_ready when idle returns",
              int'(got_rdy[idx_rdy]), 1);
        check(got_rdy[idx_rdy - 1] === 1'b0, "R6", "byte_ready one bit before idle",
              int'(got_rdy[idx_rdy - 1]), 0);
    endtask

    task automatic start_frame(input int n);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = frame[0];
        wr_last = (n == 1);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic run_frame(input int n, input int idle, input int stall,
                             input int dmin, input int dmax, input string req);
        int idx_rdy;
        idle_len = IDLE_W'(idle);
        build_expected(n, stall, idle, idx_rdy);
        start_frame(n);
        fork
            feeder(n, stall, dmin, dmax);
            monitor();
        join
        compare(req, idx_rdy);
        if (n == 1 && stall < 0) begin
            int early = 0;
            for (int k = 0; k < idx_rdy; k++) if (got_rdy[k] !== 1'b0) early++;
            check(early == 0, "R11", "ready raised after last byte", early, 0);
        end
    endtask

    task automatic run_abort(input int m, input int idle, input string req);
        int idx_rdy;
        int dummy;
        idle_len = IDLE_W'(idle);
        build_expected(2, -1, idle, dummy);
        exp_len = m + 1;
        for (int k = 0; k < 7 + idle + 2; k++) push(1'b1);
        idx_rdy = m + 7 + idle;
        start_frame(2);
        fork
            begin
                repeat (m) @(negedge clk);
                abort_req = 1'b1;
                @(negedge clk);
                abort_req = 1'b0;
                // write while not ready: must be ignored (R10)
                wr_en   = 1'b1;
                wr_data = 8'h00;
                wr_last = 1'b1;
                @(negedge clk);
                wr_en   = 1'b0;
            end
            monitor();
        join
        compare(req, idx_rdy);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_bit === 1'b1, "R1", "tx_bit after reset", int'(tx_bit), 1);
        check(byte_ready === 1'b1, "R1", "byte_ready after reset", int'(byte_ready), 1);

        // R10: abort request in idle has no effect
        abort_req = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(tx_bit === 1'b1 && byte_ready === 1'b1, "R10",
                  "idle outputs under abort_req", int'({tx_bit, byte_ready}), 3);
        end
        abort_req = 1'b0;

        // directed: single byte, checks opening flag, data, FCS, closing, ready
        frame[0] = 8'hA5;
        run_frame(1, 3, -1, 0, 0, "R2/R3/R5/R11");

        // directed: all-ones payload exercises zero insertion
        for (int i = 0; i < 4; i++) frame[i] = 8'hFF;
        run_frame(4, 0, -1, 0, 3, "R4");

        // directed: flag value inside data must be stuffed
        frame[0] = 8'h7E; frame[1] = 8'h3F; frame[2] = 8'hF8;
        run_frame(3, 15, -1, 1, 1, "R4/R3");

        // directed: every byte written on the seventh pulse of the window
        for (int i = 0; i < 5; i++) frame[i] = 8'(8'h11 * (i + 1));
        run_frame(5, 2, -1, 6, 6, "R7");

        // underrun: window missed for the second and fourth byte
        for (int i = 0; i < 6; i++) frame[i] = 8'($urandom);
        run_frame(6, 2, 1, 0, 6, "R8");
        for (int i = 0; i < 6; i++) frame[i] = 8'hF0 ^ 8'(i);
        run_frame(6, 0, 3, 0, 6, "R8");

        // forced abort during the opening flag and during data
        frame[0] = 8'hFF; frame[1] = 8'h00;
        run_abort(3, 1, "R9");
        run_abort(12, 4, "R9/R10");

        // random frames
        for (int f = 0; f < 20; f++) begin
            int n;
            n = int'($urandom_range(6, 1));
            for (int i = 0; i < n; i++)
                frame[i] = ($urandom_range(3, 0) == 0) ? 8'hFF : 8'($urandom);
            run_frame(n, int'($urandom_range(5, 0)), -1, 0, 6, "R3/R4/R5/R7");
        end

        // line remains idle after the last frame
        repeat (4) begin
            @(negedge clk);
            check(tx_bit === 1'b1, "R1", "idle line", int'(tx_bit), 1);
        end
        finish_run();
    end

endmodule